// File: doc/BRIEF.md
# Disk DMA Receive Engine

This block moves data from a parallel disk drive to the host side during a DMA read. Once software has armed it with a pending-transfer bit and a device-to-host direction, the engine waits for the drive's DMA request. It then answers with an acknowledge and takes one 16-bit word from the drive per word period. Each word goes to a receive FIFO with a single-cycle write pulse.

Two burst styles are supported. Multiword style holds a read strobe high while each word is in progress. Ultra style toggles the strobe once per word. The word period comes from a programmable cycle count for each style, which replaces real cable timing.

The engine pauses at a word boundary when the FIFO is full, the drive drops its request, software clears the pending bit, or the host reads a drive register. It resumes by itself when the cause goes away. An idle flag shows when no word is in flight, so the host may drain the FIFO.

Top module: `disk_dma_rx`

## Requirements
- R1: A transfer starts only while `ctl_pending`=1 and `ctl_write`=0; `ctl_write`=1 (host-to-device) or `ctl_pending`=0 keeps `drv_dmack` low whatever `drv_dmarq` does.
- R2: When armed, `drv_dmarq`=1, `fifo_full`=0 and `host_reg_rd`=0, `drv_dmack` rises at the next clock edge. Each word then lasts N cycles, with the write pulse in the word's last cycle; a count of 0 is treated as N=1.
- R3: `ctl_ultra`=1 selects `cyc_udma` as N and 0 selects `cyc_mdma`; the choice is sampled at every word start.
- R4: Each `fifo_wr` pulse carries the `drv_data` present in that cycle. Words reach the FIFO in drive order, none lost and none repeated.
- R5: While `fifo_full`=1 no write occurs; a word in progress stalls at its last cycle with `drv_dmack` held high and completes once space appears.
- R6: If `drv_dmarq` drops or `ctl_pending` clears during a word, that word still completes and is written. `drv_dmack` falls at the edge after that write, and no new word starts.
- R7: A host drive-register read (`host_reg_rd`=1) pauses the burst at the next word boundary and prevents a new burst from starting.
- R8: Once every pause cause is gone, the transfer resumes with no further control change, following the start timing of R2.
- R9: In multiword style `drv_rd_stb` is high while a word is in progress and low after a word that ends a burst. In ultra style it toggles once for each word written.
- R10: `idle` is 1 exactly when no word is in progress, i.e. the complement of `drv_dmack`.
- R11: A synchronous active-low reset clears `drv_dmack`, `drv_rd_stb` and the word counter and sets `idle`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_pending | input | 1 | Transfer pending enable |
| ctl_write | input | 1 | Direction, 0 = device to host |
| ctl_ultra | input | 1 | Burst style, 1 = ultra, 0 = multiword |
| cyc_mdma | input | CW | Word period in cycles, multiword style |
| cyc_udma | input | CW | Word period in cycles, ultra style |
| drv_dmarq | input | 1 | Drive DMA request |
| drv_data | input | DW | Drive data word |
| host_reg_rd | input | 1 | Host drive-register read in progress |
| fifo_full | input | 1 | Receive FIFO full |
| drv_dmack | output | 1 | DMA acknowledge to the drive |
| drv_rd_stb | output | 1 | Read strobe to the drive |
| fifo_wr | output | 1 | FIFO write pulse |
| fifo_wdata | output | DW | FIFO write data |
| idle | output | 1 | No word in progress |

## Verification
The embedded assertions check these rules on every cycle:
- the acknowledge never rises without an armed request;
- it is never dropped mid-word or while stalled on a full FIFO;
- a host read holds the engine idle;
- the strobe toggles or falls correctly after each word.

Only the bench scenarios can show the rest: word counts and spacing for each style and period, including a zero count; that data arrives in drive order with nothing lost across stalls and pauses; and that each pause cause releases the acknowledge after exactly one more word and recovers by itself.

// File: rtl/disk_dma_pkg.sv
`timescale 1ns/1ps
package disk_dma_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_XFER = 1'b1
    } rx_state_e;
endpackage

// File: rtl/dma_word_timer.sv
`timescale 1ns/1ps
module dma_word_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] len,
    output logic          zero
);
    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (load) begin
            tmr_d.cnt = (len == '0) ? '0 : len - CW'(1);
        end else if (tmr_q.cnt != '0) begin
            tmr_d.cnt = tmr_q.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign zero = (tmr_q.cnt == '0);
endmodule

// File: rtl/dma_rd_strobe.sv
`timescale 1ns/1ps
module dma_rd_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic word_start,
    input  logic word_done,
    input  logic start_ultra,
    output logic stb
);
    typedef struct packed {
        logic ultra;
        logic stb;
    } stb_t;

    stb_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (word_done) begin
            s_d.stb = s_q.ultra ? ~s_q.stb : 1'b0;
        end
        if (word_start) begin
            s_d.ultra = start_ultra;
            if (!start_ultra) s_d.stb = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign stb = s_q.stb;

    // R9
    ultra_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_done && s_q.ultra && !word_start) |=> (stb != $past(stb)));

    // R9
    mdma_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_done && !s_q.ultra && !word_start) |=> !stb);
endmodule

// File: rtl/disk_dma_rx.sv
`timescale 1ns/1ps
module disk_dma_rx #(
    parameter int DW = 16,
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctl_pending,
    input  logic          ctl_write,
    input  logic          ctl_ultra,
    input  logic [CW-1:0] cyc_mdma,
    input  logic [CW-1:0] cyc_udma,
    input  logic          drv_dmarq,
    input  logic [DW-1:0] drv_data,
    input  logic          host_reg_rd,
    input  logic          fifo_full,
    output logic          drv_dmack,
    output logic          drv_rd_stb,
    output logic          fifo_wr,
    output logic [DW-1:0] fifo_wdata,
    output logic          idle
);
    import disk_dma_pkg::*;

    typedef struct packed {
        rx_state_e st;
        logic      ack;
        logic      idl;
    } eng_t;

    eng_t          eng_d, eng_q;
    logic          armed, go, cnt_zero, word_done, word_start;
    logic [CW-1:0] word_len;

    assign word_len = ctl_ultra ? cyc_udma : cyc_mdma;

    always_comb begin
        armed      = ctl_pending & ~ctl_write;
        go         = armed & drv_dmarq & ~fifo_full & ~host_reg_rd;
        word_done  = (eng_q.st == ST_XFER) & cnt_zero & ~fifo_full;
        word_start = 1'b0;
        eng_d      = eng_q;
        case (eng_q.st)
            ST_IDLE: begin
                if (go) begin
                    eng_d.st   = ST_XFER;
                    word_start = 1'b1;
                end
            end
            ST_XFER: begin
                if (word_done) begin
                    if (go) word_start = 1'b1;
                    else    eng_d.st   = ST_IDLE;
                end
            end
            default: eng_d.st = ST_IDLE;
        endcase
        eng_d.ack = (eng_d.st == ST_XFER);
        eng_d.idl = (eng_d.st == ST_IDLE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) eng_q <= '{st: ST_IDLE, ack: 1'b0, idl: 1'b1};
        else        eng_q <= eng_d;
    end

    dma_word_timer #(.CW(CW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (word_start),
        .len   (word_len),
        .zero  (cnt_zero)
    );

    dma_rd_strobe u_strobe (
        .clk         (clk),
        .rst_n       (rst_n),
        .word_start  (word_start),
        .word_done   (word_done),
        .start_ultra (ctl_ultra),
        .stb         (drv_rd_stb)
    );

    assign drv_dmack  = eng_q.ack;
    assign idle       = eng_q.idl;
    assign fifo_wr    = word_done;
    assign fifo_wdata = drv_data;

    // R1
    start_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drv_dmack) |-> $past(ctl_pending && !ctl_write && drv_dmarq));

    // R5
    full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_dmack && fifo_full) |=> drv_dmack);

    // R6
    ack_mid_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_dmack && !cnt_zero) |=> drv_dmack);

    // R7
    host_rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!drv_dmack && host_reg_rd) |=> !drv_dmack);
endmodule

// File: tb/disk_dma_rx_bench.sv
`timescale 1ns/1ps
module disk_dma_rx_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_pending = 1'b0, ctl_write = 1'b0, ctl_ultra = 1'b0;
    logic [3:0]  cyc_mdma = 4'd3, cyc_udma = 4'd2;
    logic        drv_dmarq = 1'b0, host_reg_rd = 1'b0, fifo_full = 1'b0;
    logic [15:0] drv_data;
    logic        drv_dmack, drv_rd_stb, fifo_wr, idle;
    logic [15:0] fifo_wdata;

    int total = 0, fails = 0;
    bit done = 1'b0;
    logic [15:0] exp_q[$];
    logic [15:0] exp_w;

    always #2.5 clk = ~clk;

    disk_dma_rx u_disk_dma_rx (
        .clk(clk), .rst_n(rst_n), .ctl_pending(ctl_pending), .ctl_write(ctl_write),
        .ctl_ultra(ctl_ultra), .cyc_mdma(cyc_mdma), .cyc_udma(cyc_udma),
        .drv_dmarq(drv_dmarq), .drv_data(drv_data), .host_reg_rd(host_reg_rd),
        .fifo_full(fifo_full), .drv_dmack(drv_dmack), .drv_rd_stb(drv_rd_stb),
        .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata), .idle(idle)
    );

    function automatic logic [15:0] nxt(input logic [15:0] x);
        return {x[14:0], x[15] ^ x[13] ^ x[12] ^ x[10]};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk); #1;
    endtask

    task automatic run(input int n, output int wr, output int tog);
        logic prev;
        wr = 0; tog = 0; prev = drv_rd_stb;
        repeat (n) begin
            @(negedge clk);
            if (fifo_wr) wr++;
            if (drv_rd_stb != prev) tog++;
            prev = drv_rd_stb;
        end
    endtask

    // scoreboard monitor: the drive model presents a new word after each write
    initial begin
        drv_data = 16'hACE1;
        exp_q.push_back(16'hACE1);
    end

    always @(negedge clk) begin
        if (rst_n && fifo_wr) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R4", "unexpected write", 1, 0);
            end else begin
                exp_w = exp_q.pop_front();
                chk(fifo_wdata == exp_w, "R4", "word data", int'(fifo_wdata), int'(exp_w));
            end
            drv_data = nxt(drv_data);
            exp_q.push_back(drv_data);
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        int wr, tog;
        repeat (3) cyc();
        rst_n = 1'b1;
        @(negedge clk);
        // R11 / R10 reset state
        chk(drv_dmack == 1'b0, "R11", "dmack after reset", drv_dmack, 0);
        chk(idle == 1'b1, "R10", "idle after reset", idle, 1);
        chk(drv_rd_stb == 1'b0, "R11", "strobe after reset", drv_rd_stb, 0);
        chk(fifo_wr == 1'b0, "R11", "no write after reset", fifo_wr, 0);

        // R1: host-to-device direction never starts
        cyc(); ctl_pending = 1; ctl_write = 1; drv_dmarq = 1;
        run(12, wr, tog);
        chk(wr == 0 && drv_dmack == 0, "R1", "write dir blocked", wr, 0);
        cyc(); ctl_pending = 0; ctl_write = 0;
        run(12, wr, tog);
        chk(wr == 0 && drv_dmack == 0, "R1", "pending clear blocked", wr, 0);
        cyc(); drv_dmarq = 0;

        // R2 / R3 multiword, N=3
        cyc(); ctl_pending = 1; ctl_ultra = 0; drv_dmarq = 1;
        run(3*3+2, wr, tog);
        chk(wr == 3, "R2", "mdma words in 11 cycles", wr, 3);
        chk(tog == 1, "R9", "mdma strobe held high", tog, 1);
        chk(idle == 0 && drv_dmack == 1, "R10", "idle low while busy", idle, 0);
        cyc(); drv_dmarq = 0;
        run(8, wr, tog);
        chk(drv_dmack == 0 && idle == 1, "R10", "idle after stop", idle, 1);
        chk(drv_rd_stb == 0, "R9", "mdma strobe low when paused", drv_rd_stb, 0);

        // R3 ultra, N=2
        cyc(); ctl_ultra = 1; drv_dmarq = 1;
        run(4*2+2, wr, tog);
        chk(wr == 4, "R3", "udma words in 10 cycles", wr, 4);
        chk(tog == 4, "R9", "udma strobe toggles", tog, 4);
        cyc(); drv_dmarq = 0;
        run(6, wr, tog);

        // R2 zero count means one cycle per word
        cyc(); ctl_ultra = 0; cyc_mdma = 4'd0; drv_dmarq = 1;
        run(6, wr, tog);
        chk(wr == 5, "R2", "zero count words", wr, 5);
        cyc(); drv_dmarq = 0;
        run(4, wr, tog);
        cyc(); cyc_mdma = 4'd3;

        // R5 full FIFO stalls the word with ack held
        cyc(); drv_dmarq = 1;
        cyc(); cyc();
        fifo_full = 1;
        run(10, wr, tog);
        chk(wr == 0, "R5", "no write while full", wr, 0);
        chk(drv_dmack == 1, "R5", "ack held while full", drv_dmack, 1);
        cyc(); fifo_full = 0;
        run(7, wr, tog);
        chk(wr == 3, "R5", "words after full clears", wr, 3);
        cyc(); drv_dmarq = 0;
        run(8, wr, tog);

        // R6 / R7 / R8 pause causes, N=4
        cyc_mdma = 4'd4;
        for (int c = 0; c < 3; c++) begin
            cyc(); drv_dmarq = 1; ctl_pending = 1; host_reg_rd = 0;
            cyc(); cyc();
            if (c == 0) drv_dmarq = 0;
            else if (c == 1) ctl_pending = 0;
            else host_reg_rd = 1;
            @(negedge clk);
            chk(drv_dmack == 1, (c == 2) ? "R7" : "R6", "ack kept mid word", drv_dmack, 1);
            run(6, wr, tog);
            chk(wr == 1, (c == 2) ? "R7" : "R6", "word completes on pause", wr, 1);
            chk(drv_dmack == 0 && idle == 1, (c == 2) ? "R7" : "R6", "ack released", drv_dmack, 0);
            run(8, wr, tog);
            chk(wr == 0, (c == 2) ? "R7" : "R6", "stays paused", wr, 0);
            cyc(); drv_dmarq = 1; ctl_pending = 1; host_reg_rd = 0;
            run(2*4+2, wr, tog);
            chk(wr == 2, "R8", "auto resume", wr, 2);
            cyc(); drv_dmarq = 0;
            run(10, wr, tog);
        end

        // R4 nothing lost: only the currently presented word remains
        chk(exp_q.size() == 1, "R4", "scoreboard drained", exp_q.size(), 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule